// File: doc/BRIEF.md
# Shared Mailbox Slot Array with Level Interrupts

This block holds a small array of one-word message slots through which two agents exchange data. One agent posts a message by writing a slot with its top bit set. That bit is the slot's FULL flag and lives inside the message word itself. The other agent takes the message and frees the slot by writing zero to the whole word. Both agents reach the block through identical register ports. Each port has a write strobe, an address, write data and read data that is registered for one cycle.

Every slot produces an EMPTY condition and a FULL condition. These are collected into one status word and gated by per-slot enables for each condition. A separate enable word for each interrupt line then masks them. The result drives level-sensitive, registered interrupt outputs. An interrupt stays high for as long as its condition, its slot enable and its line enable all hold.

A read-only sizing word reports how many slots and interrupt lines the instance was built with.

Top module: `mbx_shared_array`

## Requirements
- R1: After reset every message word is 0x0000_0000, every slot enable and line enable is 0, and every interrupt output is 0. The status word at byte address 0x304 then reads 1 in bit s for each existing slot s.
- R2: A write to slot s's message word stores all 32 bits. The word is at byte address 0x1000 + 16*s. Bit 31 is the FULL flag, so a word posted with bit 31 set reads back unchanged and marks the slot full.
- R3: Writing 0x0 to a message word clears the payload bits and the FULL flag together.
- R4: Status bit s is 1 while slot s is empty, and status bit 8+s is 1 while slot s is full. Status bits of slots that do not exist read 0.
- R5: Interrupt line i has a 16-bit enable word at byte address 0x100 + 4*i. It uses the same bit layout as the status word and reads back as written.
- R6: Each slot has a FULL enable at slot address + 0x4 and an EMPTY enable at slot address + 0x8. Only bit 0 of each is stored, and it reads back in bit 0.
- R7: Output irq[i] equals the OR over all status bits of (status bit AND line-i enable bit AND the matching slot enable). The output is registered, so it follows a state change one clock later.
- R8: The interrupts are level-sensitive. An enabled EMPTY condition keeps its line high for as long as the slot stays empty.
- R9: The sizing word at byte address 0x380 reports the slot count in bits [3:0] and the line count in bits [19:16]. All other bits are 0.
- R10: If both ports write the same register in the same cycle, the consumer port's value is stored.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses, to the status word or to the sizing word change nothing.
- R12: Read data appears on a port's read-data output on the clock edge after its address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_we | input | 1 | Producer port write strobe |
| p_addr | input | 16 | Producer port byte address |
| p_wdata | input | 32 | Producer port write data |
| p_rdata | output | 32 | Producer port read data, one cycle after address |
| c_we | input | 1 | Consumer port write strobe |
| c_addr | input | 16 | Consumer port byte address |
| c_wdata | input | 32 | Consumer port write data |
| c_rdata | output | 32 | Consumer port read data, one cycle after address |
| irq | output | N_LINE | Level-sensitive interrupt lines |

## Verification
The bench sweeps every slot through all eight combinations of FULL state, FULL enable and EMPTY enable. For each combination it applies three line-enable patterns: EMPTY bit only, FULL bit only, and both. This separates a wrong status polarity, a swapped gate and a missing line mask. A second line enabled on every bit at once shows that the lines are gated independently.

Messages with varied payloads, with and without bit 31, expose truncation or a misplaced FULL flag. A held empty slot checks that the interrupt level persists. Colliding writes from both ports, and writes to read-only and unmapped addresses, check the priority rule and that such writes are ignored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [15:0] LINE_BASE = 16'h0100;
  localparam logic [15:0] STAT_ADDR = 16'h0304;
  localparam logic [15:0] DIM_ADDR  = 16'h0380;
  localparam logic [3:0]  SLOT_PAGE = 4'h1;
  localparam int          ST_W      = 16;
  localparam int          FULL_OFS  = 8;

  typedef enum logic [1:0] {
    FLD_MSG = 2'd0,
    FLD_FIE = 2'd1,
    FLD_EIE = 2'd2
  } slot_fld_e;

  typedef struct packed {
    logic       slot_hit;
    logic [3:0] slot;
    logic [1:0] fld;
    logic       line_hit;
    logic [5:0] line;
    logic       stat_hit;
    logic       dim_hit;
  } dec_t;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 32,
  parameter bit HAS_IE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_msg,
  input  logic [DATA_W-1:0] msg_d,
  input  logic              wr_fie,
  input  logic              fie_d,
  input  logic              wr_eie,
  input  logic              eie_d,
  output logic [DATA_W-1:0] msg_o,
  output logic              full_o,
  output logic              fie_o,
  output logic              eie_o
);
  logic [DATA_W-1:0] msg_q;

  always_ff @(posedge clk) begin
    if (rst)         msg_q <= '0;
    else if (wr_msg) msg_q <= msg_d;
  end

  assign msg_o  = msg_q;
  assign full_o = msg_q[DATA_W-1];

  generate
    if (HAS_IE) begin : g_ie
      logic fie_q, eie_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          fie_q <= 1'b0;
          eie_q <= 1'b0;
        end else begin
          if (wr_fie) fie_q <= fie_d;
          if (wr_eie) eie_q <= eie_d;
        end
      end
      assign fie_o = fie_q;
      assign eie_o = eie_q;

      a_r6_fie_write: assert property (@(posedge clk) disable iff (rst)
        wr_fie |=> (fie_o == $past(fie_d)));
      a_r6_eie_write: assert property (@(posedge clk) disable iff (rst)
        wr_eie |=> (eie_o == $past(eie_d)));
    end else begin : g_no_ie
      logic unused_ie;
      assign unused_ie = wr_fie ^ fie_d ^ wr_eie ^ eie_d;
      assign fie_o = 1'b1;
      assign eie_o = 1'b1;
    end
  endgenerate

  a_r2_post_sets_full: assert property (@(posedge clk) disable iff (rst)
    (wr_msg && msg_d[DATA_W-1]) |=> (full_o && msg_o == $past(msg_d)));
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_msg && msg_d == '0) |=> (msg_o == '0 && !full_o));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int N_LINE = 2,
  parameter int ST_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ST_W-1:0]             status,
  input  logic [ST_W-1:0]             gate,
  input  logic [N_LINE-1:0]           wr_en,
  input  logic [N_LINE-1:0][ST_W-1:0] wdata,
  output logic [N_LINE-1:0][ST_W-1:0] en_o,
  output logic [N_LINE-1:0]           irq_o
);
  logic [N_LINE-1:0][ST_W-1:0] en_q;
  logic [N_LINE-1:0]           irq_q;

  generate
    for (genvar i = 0; i < N_LINE; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q[i]  <= '0;
          irq_q[i] <= 1'b0;
        end else begin
          if (wr_en[i]) en_q[i] <= wdata[i];
          irq_q[i] <= |(status & en_q[i] & gate);
        end
      end

      a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        ((status & en_o[i] & gate) == '0) |=> !irq_o[i]);
      a_r8_level_held: assert property (@(posedge clk) disable iff (rst)
        ((status & en_o[i] & gate) != '0) |=> irq_o[i]);
      a_r5_en_write: assert property (@(posedge clk) disable iff (rst)
        wr_en[i] |=> (en_o[i] == $past(wdata[i])));
    end
  endgenerate

  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mbx_shared_array.sv
module mbx_shared_array #(
  parameter int N_SLOT = 4,
  parameter int N_LINE = 2,
  parameter bit HAS_IE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p_we,
  input  logic [15:0]       p_addr,
  input  logic [31:0]       p_wdata,
  output logic [31:0]       p_rdata,
  input  logic              c_we,
  input  logic [15:0]       c_addr,
  input  logic [31:0]       c_wdata,
  output logic [31:0]       c_rdata,
  output logic [N_LINE-1:0] irq
);
  import mbx_pkg::*;

  localparam logic [31:0] DIM_WORD = {12'd0, 4'(N_LINE), 12'd0, 4'(N_SLOT)};

  initial begin
    if (N_SLOT < 1 || N_SLOT > 8)  $error("N_SLOT out of range");
    if (N_LINE < 1 || N_LINE > 15) $error("N_LINE out of range");
  end

  logic [31:0]                 slot_msg [N_SLOT];
  logic [N_SLOT-1:0]           slot_full, slot_fie, slot_eie;
  logic [ST_W-1:0]             status, gate;
  logic [N_LINE-1:0][ST_W-1:0] line_en;
  logic [N_LINE-1:0]           line_wr;
  logic [N_LINE-1:0][ST_W-1:0] line_wd;
  dec_t                        p_dc, c_dc;

  function automatic dec_t decode(input logic [15:0] a);
    dec_t d;
    d          = '0;
    d.slot     = a[7:4];
    d.fld      = a[3:2];
    d.line     = a[7:2];
    d.slot_hit = (a[15:12] == SLOT_PAGE) && (a[11:8] == 4'd0) &&
                 (a[1:0] == 2'd0) && (int'(a[7:4]) < N_SLOT) && (a[3:2] != 2'd3);
    d.line_hit = (a[15:8] == LINE_BASE[15:8]) && (a[1:0] == 2'd0) &&
                 (int'(a[7:2]) < N_LINE);
    d.stat_hit = (a == STAT_ADDR);
    d.dim_hit  = (a == DIM_ADDR);
    return d;
  endfunction

  assign p_dc = decode(p_addr);
  assign c_dc = decode(c_addr);

  // Slot storage: consumer port wins a same-cycle collision.
  generate
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      logic [2:0] p_hit, c_hit;
      for (genvar f = 0; f < 3; f++) begin : g_fld
        assign p_hit[f] = p_we && p_dc.slot_hit && (int'(p_dc.slot) == s) && (int'(p_dc.fld) == f);
        assign c_hit[f] = c_we && c_dc.slot_hit && (int'(c_dc.slot) == s) && (int'(c_dc.fld) == f);
      end
      logic [31:0] wd_msg, wd_fie, wd_eie;
      assign wd_msg = c_hit[FLD_MSG] ? c_wdata : p_wdata;
      assign wd_fie = c_hit[FLD_FIE] ? c_wdata : p_wdata;
      assign wd_eie = c_hit[FLD_EIE] ? c_wdata : p_wdata;

      mbx_slot #(.DATA_W(32), .HAS_IE(HAS_IE)) i_slot (
        .clk    (clk),
        .rst    (rst),
        .wr_msg (p_hit[FLD_MSG] | c_hit[FLD_MSG]),
        .msg_d  (wd_msg),
        .wr_fie (p_hit[FLD_FIE] | c_hit[FLD_FIE]),
        .fie_d  (wd_fie[0]),
        .wr_eie (p_hit[FLD_EIE] | c_hit[FLD_EIE]),
        .eie_d  (wd_eie[0]),
        .msg_o  (slot_msg[s]),
        .full_o (slot_full[s]),
        .fie_o  (slot_fie[s]),
        .eie_o  (slot_eie[s])
      );

      a_r10_consumer_wins: assert property (@(posedge clk) disable iff (rst)
        (p_we && c_we && p_addr == c_addr && c_hit[FLD_MSG]) |=> (slot_msg[s] == $past(c_wdata)));
    end

    for (genvar l = 0; l < N_LINE; l++) begin : g_lwr
      logic pl, cl;
      assign pl         = p_we && p_dc.line_hit && (int'(p_dc.line) == l);
      assign cl         = c_we && c_dc.line_hit && (int'(c_dc.line) == l);
      assign line_wr[l] = pl | cl;
      assign line_wd[l] = cl ? c_wdata[ST_W-1:0] : p_wdata[ST_W-1:0];
    end
  endgenerate

  always_comb begin
    status = '0;
    gate   = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      status[s]          = ~slot_full[s];
      status[FULL_OFS+s] =  slot_full[s];
      gate[s]            =  slot_eie[s];
      gate[FULL_OFS+s]   =  slot_fie[s];
    end
  end

  mbx_irq #(.N_LINE(N_LINE), .ST_W(ST_W)) i_irq (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .gate   (gate),
    .wr_en  (line_wr),
    .wdata  (line_wd),
    .en_o   (line_en),
    .irq_o  (irq)
  );

  function automatic logic [31:0] rd_word(input dec_t d);
    logic [31:0] v;
    v = '0;
    if (d.slot_hit) begin
      for (int s = 0; s < N_SLOT; s++) begin
        if (int'(d.slot) == s) begin
          case (d.fld)
            FLD_MSG: v = slot_msg[s];
            FLD_FIE: v = {31'd0, slot_fie[s]};
            default: v = {31'd0, slot_eie[s]};
          endcase
        end
      end
    end else if (d.line_hit) begin
      for (int l = 0; l < N_LINE; l++)
        if (int'(d.line) == l) v = {16'd0, line_en[l]};
    end else if (d.stat_hit) begin
      v = {16'd0, status};
    end else if (d.dim_hit) begin
      v = DIM_WORD;
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      p_rdata <= '0;
      c_rdata <= '0;
    end else begin
      p_rdata <= rd_word(p_dc);
      c_rdata <= rd_word(c_dc);
    end
  end

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!p_dc.slot_hit && !p_dc.line_hit && !p_dc.stat_hit && !p_dc.dim_hit) |=> (p_rdata == '0));
  a_r9_dim_word: assert property (@(posedge clk) disable iff (rst)
    c_dc.dim_hit |=> (c_rdata == DIM_WORD));
  a_r4_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    (status[N_SLOT-1:0] & status[FULL_OFS +: N_SLOT]) == '0);
endmodule

// File: tb/test_mbx_shared_array.sv
module test_mbx_shared_array;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NL = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          p_we = 1'b0, c_we = 1'b0;
  logic [15:0]   p_addr = '0, c_addr = '0;
  logic [31:0]   p_wdata = '0, c_wdata = '0;
  logic [31:0]   p_rdata, c_rdata;
  logic [NL-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] msg_m [NS];
  logic        fie_m [NS];
  logic        eie_m [NS];
  logic [15:0] len_m [NL];

  mbx_shared_array #(.N_SLOT(NS), .N_LINE(NL), .HAS_IE(1'b1)) i_mbx_shared_array (
    .clk(clk), .rst(rst),
    .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] a_msg(int s); return 16'h1000 + 16'(s * 16); endfunction
  function automatic logic [15:0] a_fie(int s); return a_msg(s) + 16'h4; endfunction
  function automatic logic [15:0] a_eie(int s); return a_msg(s) + 16'h8; endfunction
  function automatic logic [15:0] a_len(int l); return 16'h0100 + 16'(l * 4); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model of a single write, following the requirements.
  task automatic model_wr(input logic [15:0] a, input logic [31:0] d);
    for (int s = 0; s < NS; s++) begin
      if (a == a_msg(s)) msg_m[s] = d;
      if (a == a_fie(s)) fie_m[s] = d[0];
      if (a == a_eie(s)) eie_m[s] = d[0];
    end
    for (int l = 0; l < NL; l++) if (a == a_len(l)) len_m[l] = d[15:0];
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] v = '0;
    for (int s = 0; s < NS; s++) begin
      v[s]   = ~msg_m[s][31];
      v[8+s] =  msg_m[s][31];
    end
    return v;
  endfunction

  function automatic logic exp_irq(int l);
    logic [15:0] g = '0;
    for (int s = 0; s < NS; s++) begin
      g[s]   = eie_m[s];
      g[8+s] = fie_m[s];
    end
    return |(exp_status() & len_m[l] & g);
  endfunction

  task automatic wr(input logic cons, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    if (cons) begin c_we = 1'b1; c_addr = a; c_wdata = d; end
    else      begin p_we = 1'b1; p_addr = a; p_wdata = d; end
    @(negedge clk);
    p_we = 1'b0; c_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    p_addr = a;
    @(negedge clk);
    v = p_rdata;
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    for (int l = 0; l < NL; l++) chk(req, 32'(irq[l]), 32'(exp_irq(l)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int s = 0; s < NS; s++) begin msg_m[s] = '0; fie_m[s] = 1'b0; eie_m[s] = 1'b0; end
    for (int l = 0; l < NL; l++) len_m[l] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    rd(16'h0304, v); chk("R1 status", v, 32'h0000_000F);
    for (int s = 0; s < NS; s++) begin
      rd(a_msg(s), v); chk("R1 msg", v, 32'd0);
      rd(a_fie(s), v); chk("R1 fie", v, 32'd0);
      rd(a_eie(s), v); chk("R1 eie", v, 32'd0);
    end
    for (int l = 0; l < NL; l++) begin rd(a_len(l), v); chk("R1 len", v, 32'd0); end

    // R9 sizing word
    rd(16'h0380, v); chk("R9 dim", v, 32'h0002_0004);

    // R12 latency: rdata reflects the address of the previous edge
    @(negedge clk); p_addr = 16'h0380;
    @(posedge clk); #1;
    chk("R12 latency", p_rdata, 32'h0002_0004);

    // R2 / R3 / R4 posting and clearing with varied payloads
    for (int s = 0; s < NS; s++) begin
      logic [31:0] w;
      w = 32'h8000_0000 | 32'((s + 1) * 32'h0123_4567) & 32'h7FFF_FFFF;
      wr(1'b0, a_msg(s), w);
      rd(a_msg(s), v); chk("R2 post", v, w);
      rd(16'h0304, v); chk("R4 status full", v, {16'd0, exp_status()});
      wr(1'b1, a_msg(s), 32'd0);
      rd(a_msg(s), v); chk("R3 clear", v, 32'd0);
      rd(16'h0304, v); chk("R4 status empty", v, {16'd0, exp_status()});
    end
    wr(1'b0, a_msg(1), 32'h0000_5A5A);
    rd(a_msg(1), v); chk("R2 no flag", v, 32'h0000_5A5A);
    rd(16'h0304, v); chk("R4 no flag", v, 32'h0000_000F);
    wr(1'b1, a_msg(1), 32'd0);

    // R5 / R6 readback
    wr(1'b0, a_len(0), 32'hFFFF_A55A);
    rd(a_len(0), v); chk("R5 len0", v, 32'h0000_A55A);
    wr(1'b0, a_len(1), 32'h0000_3CC3);
    rd(a_len(1), v); chk("R5 len1", v, 32'h0000_3CC3);
    wr(1'b0, a_fie(2), 32'hFFFF_FFFF);
    rd(a_fie(2), v); chk("R6 fie", v, 32'd1);
    wr(1'b0, a_eie(3), 32'h0000_0003);
    rd(a_eie(3), v); chk("R6 eie", v, 32'd1);
    wr(1'b0, a_fie(2), 32'd0);
    wr(1'b0, a_eie(3), 32'd0);
    wr(1'b0, a_len(0), 32'd0);
    wr(1'b0, a_len(1), 32'd0);

    // R7 sweep: slot x {full, fie, eie} x line-0 pattern, line 1 all bits
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 3; k++) begin
          wr(1'b0, a_msg(s), c[0] ? (32'h8000_0000 | 32'(c)) : 32'd0);
          wr(1'b0, a_fie(s), 32'(c[1]));
          wr(1'b1, a_eie(s), 32'(c[2]));
          wr(1'b0, a_len(0), (k == 0) ? 32'(16'd1 << s) :
                             (k == 1) ? 32'(16'h100 << s) :
                                        32'((16'd1 << s) | (16'h100 << s)));
          wr(1'b0, a_len(1), 32'h0000_FFFF);
          chk_irq("R7 sweep");
        end
      end
      wr(1'b1, a_msg(s), 32'd0);
      wr(1'b1, a_fie(s), 32'd0);
      wr(1'b1, a_eie(s), 32'd0);
    end

    // R8 level: empty slot with EMPTY enabled holds the line
    wr(1'b0, a_len(0), 32'h0000_0004);
    wr(1'b0, a_len(1), 32'd0);
    wr(1'b0, a_eie(2), 32'd1);
    @(negedge clk);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk); chk("R8 held", 32'(irq[0]), 32'd1);
    end
    wr(1'b0, a_msg(2), 32'h8000_0001);
    chk_irq("R8 drop when full");
    chk("R8 low", 32'(irq[0]), 32'd0);
    wr(1'b1, a_msg(2), 32'd0);
    chk_irq("R8 back high");
    chk("R8 high", 32'(irq[0]), 32'd1);

    // R10 same-cycle collision
    @(negedge clk);
    p_we = 1'b1; p_addr = a_msg(0); p_wdata = 32'h8000_00AB;
    c_we = 1'b1; c_addr = a_msg(0); c_wdata = 32'd0;
    @(negedge clk);
    p_we = 1'b0; c_we = 1'b0;
    rd(a_msg(0), v); chk("R10 msg consumer wins", v, 32'd0);
    @(negedge clk);
    p_we = 1'b1; p_addr = a_len(1); p_wdata = 32'h0000_1111;
    c_we = 1'b1; c_addr = a_len(1); c_wdata = 32'h0000_2222;
    @(negedge clk);
    p_we = 1'b0; c_we = 1'b0;
    rd(a_len(1), v); chk("R10 len consumer wins", v, 32'h0000_2222);

    // R11 unmapped and read-only writes
    wr(1'b0, 16'h0304, 32'hFFFF_FFFF);
    rd(16'h0304, v); chk("R11 status ro", v, 32'h0000_000F);
    wr(1'b0, 16'h0380, 32'hFFFF_FFFF);
    rd(16'h0380, v); chk("R11 dim ro", v, 32'h0002_0004);
    wr(1'b0, 16'h1040, 32'h8000_0001);
    rd(16'h1040, v); chk("R11 absent slot", v, 32'd0);
    rd(16'h0304, v); chk("R11 absent slot status", v, 32'h0000_000F);
    wr(1'b0, 16'h0108, 32'h0000_FFFF);
    rd(16'h0108, v); chk("R11 absent line", v, 32'd0);
    rd(16'h2000, v); chk("R11 unmapped", v, 32'd0);
    rd(16'h100C, v); chk("R11 slot hole", v, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule